// File: doc/BRIEF.md
# Frame-Indexed Page Translation Search Engine

This block translates a virtual address into a physical address using a table that has one slot per physical frame. Each slot records which virtual page number that frame currently holds, plus a valid flag. The table is indexed by frame and not by page, so a translation cannot be done with one indexed read. The block searches the slots one per clock, starting at slot 0. The first valid slot whose stored page number equals the requested one gives the frame number, which is the slot's index. The physical address is that frame number placed above the untouched 12-bit page offset. If the search reaches the last slot without a match, the block reports a miss.

The requester raises `req_i` with the address while the block is idle. It then watches `busy_o` during the search and takes the one-cycle `done_o` pulse, qualified by `hit_o` or `miss_o`. Slots are loaded through a write port that carries a frame index, a page number and a valid flag. Writes take effect only while the block is idle.

The controller has four states:
- `ST_IDLE` waits for a request.
- `ST_SCAN` examines one slot per cycle.
- `ST_HIT` and `ST_MISS` each last one cycle and carry the result.

The transitions are:
- IDLE→SCAN when a request is taken.
- SCAN→SCAN when the current slot does not match and it is not the last slot.
- SCAN→HIT on a match.
- SCAN→MISS when the last slot does not match.
- HIT→IDLE and MISS→IDLE unconditionally.

Top module: `ipt_search`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `hit_o` and `miss_o` are 0 and `paddr_o` is 0. Every slot is invalid, so any lookup then misses.
- R2: On a hit, `paddr_o` equals the matching slot index in the upper `FRAME_W` bits and `vaddr_i[11:0]` of the request in the low 12 bits. It is presented in the cycle in which `done_o` and `hit_o` are 1.
- R3: A slot written with valid flag 0 never matches, even when its stored page number equals the requested one.
- R4: When several valid slots hold the requested page number, the lowest slot index is returned.
- R5: The cycle in which the request is taken is cycle 0. For a match in slot j, `done_o` is 1 in cycle j+2.
- R6: When no valid slot matches, `done_o` and `miss_o` are 1 in cycle FRAMES+1, with `hit_o` at 0. `paddr_o` keeps the value it had before the lookup.
- R7: `done_o` is a single-cycle pulse. `hit_o` and `miss_o` are 1 only together with `done_o`, and never both at once.
- R8: A request raised while `busy_o` is 1 is ignored. The running search completes with its own result, and no further `done_o` follows for the ignored request.
- R9: A table write presented while `busy_o` is 1 is discarded, and the slot keeps its previous contents.
- R10: `busy_o` is 1 in every cycle from cycle 1 up to the cycle before `done_o`, and it is 0 in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a lookup (taken only when idle) |
| vaddr_i | input | VA_W | Virtual address to translate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| hit_o | output | 1 | Result is a hit (with done_o) |
| miss_o | output | 1 | Result is a miss (with done_o) |
| paddr_o | output | PA_W | Translated physical address, FRAME_W+12 bits |
| wr_en_i | input | 1 | Table write strobe (taken only when idle) |
| wr_idx_i | input | FRAME_W | Frame slot to write |
| wr_vpn_i | input | VPN_W | Virtual page number to store |
| wr_valid_i | input | 1 | Valid flag to store |

## Verification
The bench builds the block with FRAMES=8, VA_W=32 and OFFSET_W=12. This gives a 3-bit frame number, a 15-bit physical address and a 20-bit page number. With only eight slots, the bench can reach both ends of the search: a hit in slot 0 at cycle 2, a hit in the last slot at cycle 9, and a full-length miss at cycle 9. Each case has its exact latency checked. Duplicate and invalid slots are placed around the search path to check lowest-index priority and the valid qualifier. Requests and writes issued in the middle of a search are checked for having no effect, by the results of the search and of a later lookup.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HIT  = 2'd2,
        ST_MISS = 2'd3
    } scan_state_e;
endpackage

// File: rtl/ipt_frame_table.sv
module ipt_frame_table #(
    parameter int FRAMES  = 16,
    parameter int VPN_W   = 20,
    parameter int FRAME_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic               wr_allow_i,
    input  logic [FRAME_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0]   wr_vpn_i,
    input  logic               wr_valid_i,
    input  logic [FRAME_W-1:0] rd_idx_i,
    output logic [VPN_W-1:0]   rd_vpn_o,
    output logic               rd_valid_o
);
    logic [VPN_W-1:0] vpn_q   [FRAMES];
    logic             valid_q [FRAMES];
    logic             wr_take;

    assign wr_take = wr_en_i && wr_allow_i;

    for (genvar g = 0; g < FRAMES; g++) begin : g_slot
        logic sel;
        assign sel = wr_take && (wr_idx_i == FRAME_W'(g));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                valid_q[g] <= 1'b0;
                vpn_q[g]   <= '0;
            end else if (sel) begin
                valid_q[g] <= wr_valid_i;
                vpn_q[g]   <= wr_vpn_i;
            end
        end
    end

    always_comb begin
        rd_vpn_o   = '0;
        rd_valid_o = 1'b0;
        if (int'(rd_idx_i) < FRAMES) begin
            rd_vpn_o   = vpn_q[rd_idx_i];
            rd_valid_o = valid_q[rd_idx_i];
        end
    end

    // R9
    blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_allow_i && int'(wr_idx_i) < FRAMES)
        |=> (vpn_q[$past(wr_idx_i)] == $past(vpn_q[wr_idx_i]) &&
             valid_q[$past(wr_idx_i)] == $past(valid_q[wr_idx_i])));
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
    parameter int VPN_W = 20
) (
    input  logic [VPN_W-1:0] slot_vpn_i,
    input  logic             slot_valid_i,
    input  logic [VPN_W-1:0] want_vpn_i,
    output logic             match_o
);
    always_comb begin
        match_o = slot_valid_i && (slot_vpn_i == want_vpn_i);
    end
endmodule

// File: rtl/ipt_scan_fsm.sv
module ipt_scan_fsm
    import ipt_pkg::*;
#(
    parameter int FRAMES  = 16,
    parameter int FRAME_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               match_i,
    output logic [FRAME_W-1:0] idx_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               hit_o,
    output logic               miss_o,
    output logic               load_o,
    output logic               found_o
);
    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(FRAMES - 1);

    scan_state_e       state_q, state_d;
    logic [FRAME_W-1:0] idx_q, idx_d;
    logic              at_last;

    assign at_last = (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                end
            end
            ST_SCAN: begin
                if (match_i) begin
                    state_d = ST_HIT;
                end else if (at_last) begin
                    state_d = ST_MISS;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_HIT:  state_d = ST_IDLE;
            ST_MISS: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        busy_o  = 1'b0;
        done_o  = 1'b0;
        hit_o   = 1'b0;
        miss_o  = 1'b0;
        load_o  = 1'b0;
        found_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = req_i;
            ST_SCAN: begin
                busy_o  = 1'b1;
                found_o = match_i;
            end
            ST_HIT: begin
                done_o = 1'b1;
                hit_o  = 1'b1;
            end
            ST_MISS: begin
                done_o = 1'b1;
                miss_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign idx_o = idx_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && miss_o));

    // R6
    miss_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && at_last && !match_i) |=> miss_o);

    // R4
    hit_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && match_i) |=> (hit_o && $past(idx_o) == idx_o));

    // R10
    busy_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));
endmodule

// File: rtl/ipt_search.sv
module ipt_search #(
    parameter int FRAMES   = 16,
    parameter int VA_W     = 32,
    parameter int OFFSET_W = 12,
    localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int VPN_W   = VA_W - OFFSET_W,
    localparam int PA_W    = FRAME_W + OFFSET_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic [VA_W-1:0]    vaddr_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               hit_o,
    output logic               miss_o,
    output logic [PA_W-1:0]    paddr_o,
    input  logic               wr_en_i,
    input  logic [FRAME_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0]   wr_vpn_i,
    input  logic               wr_valid_i
);
    logic [VPN_W-1:0]    want_vpn_q;
    logic [OFFSET_W-1:0] offset_q;
    logic [PA_W-1:0]     paddr_q;
    logic [FRAME_W-1:0]  scan_idx;
    logic [VPN_W-1:0]    slot_vpn;
    logic                slot_valid;
    logic                slot_match;
    logic                busy, load, found;
    logic                idle;

    assign idle = !busy && !done_o;

    ipt_frame_table #(
        .FRAMES (FRAMES),
        .VPN_W  (VPN_W),
        .FRAME_W(FRAME_W)
    ) u_table (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_allow_i(idle),
        .wr_idx_i  (wr_idx_i),
        .wr_vpn_i  (wr_vpn_i),
        .wr_valid_i(wr_valid_i),
        .rd_idx_i  (scan_idx),
        .rd_vpn_o  (slot_vpn),
        .rd_valid_o(slot_valid)
    );

    ipt_match #(.VPN_W(VPN_W)) u_match (
        .slot_vpn_i  (slot_vpn),
        .slot_valid_i(slot_valid),
        .want_vpn_i  (want_vpn_q),
        .match_o     (slot_match)
    );

    ipt_scan_fsm #(
        .FRAMES (FRAMES),
        .FRAME_W(FRAME_W)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .match_i(slot_match),
        .idx_o  (scan_idx),
        .busy_o (busy),
        .done_o (done_o),
        .hit_o  (hit_o),
        .miss_o (miss_o),
        .load_o (load),
        .found_o(found)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            want_vpn_q <= '0;
            offset_q   <= '0;
        end else if (load) begin
            want_vpn_q <= vaddr_i[VA_W-1:OFFSET_W];
            offset_q   <= vaddr_i[OFFSET_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            paddr_q <= '0;
        end else if (found) begin
            paddr_q <= {scan_idx, offset_q};
        end
    end

    assign busy_o  = busy;
    assign paddr_o = paddr_q;

    // R8
    req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && req_i) |=> ($stable(want_vpn_q) && $stable(offset_q)));

    // R2
    hit_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (paddr_o[OFFSET_W-1:0] == offset_q));

    // R6
    miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_o |-> $stable(paddr_o));
endmodule

// File: tb/test_ipt_search.sv
module test_ipt_search;
    localparam int FRAMES = 8;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int FW     = 3;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PA_W   = FW + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [VA_W-1:0]   vaddr = '0;
    logic              busy, done, hit, miss;
    logic [PA_W-1:0]   paddr;
    logic              wr_en = 1'b0;
    logic [FW-1:0]     wr_idx = '0;
    logic [VPN_W-1:0]  wr_vpn = '0;
    logic              wr_valid = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ipt_search #(.FRAMES(FRAMES), .VA_W(VA_W), .OFFSET_W(OFF_W)) i_ipt_search (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(vaddr),
        .busy_o(busy), .done_o(done), .hit_o(hit), .miss_o(miss), .paddr_o(paddr),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_valid_i(wr_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input logic [VPN_W-1:0] vpn, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = FW'(idx); wr_vpn = vpn; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Runs one lookup; returns cycle of done, hit flag, paddr
    task automatic lookup(input logic [VA_W-1:0] va, output int cyc,
                          output logic h, output logic [PA_W-1:0] pa);
        logic busy_ok = 1'b1;
        @(negedge clk);
        req = 1'b1; vaddr = va;
        @(negedge clk);
        req = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        h  = hit;
        pa = paddr;
        check("R10 busy during search", 32'(busy_ok), 32'd1);
        check("R10 busy low at done", 32'(busy), 32'd0);
        check("R7 hit/miss exclusive", 32'(hit ^ miss), 32'd1);
        @(negedge clk);
        check("R7 done single pulse", 32'(done), 32'd0);
        check("R7 hit low after pulse", 32'(hit | miss), 32'd0);
    endtask

    task automatic t_reset;
        int c; logic h; logic [PA_W-1:0] pa;
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 hit", 32'(hit), 0);
        check("R1 miss", 32'(miss), 0);
        check("R1 paddr", 32'(paddr), 0);
        lookup(32'h0000_0123, c, h, pa);
        check("R1 empty table misses", 32'(h), 0);
        check("R6 miss latency", 32'(c), FRAMES + 1);
        check("R6 paddr held", 32'(pa), 0);
    endtask

    task automatic t_basic_hit;
        int c; logic h; logic [PA_W-1:0] pa;
        write_slot(3, 20'h12345, 1'b1);
        lookup(32'h1234_5ABC, c, h, pa);
        check("R2 hit", 32'(h), 1);
        check("R2 paddr", 32'(pa), 32'h3ABC);
        check("R5 latency slot 3", 32'(c), 5);
    endtask

    task automatic t_ends;
        int c; logic h; logic [PA_W-1:0] pa;
        write_slot(0, 20'h00AAA, 1'b1);
        write_slot(7, 20'hFFFFF, 1'b1);
        lookup(32'h00AA_A001, c, h, pa);
        check("R5 latency slot 0", 32'(c), 2);
        check("R2 paddr slot 0", 32'(pa), 32'h0001);
        lookup(32'hFFFF_FFFE, c, h, pa);
        check("R5 latency last slot", 32'(c), FRAMES + 1);
        check("R2 hit last slot", 32'(h), 1);
        check("R2 paddr last slot", 32'(pa), 32'h7FFE);
    endtask

    task automatic t_invalid;
        int c; logic h; logic [PA_W-1:0] pa;
        write_slot(5, 20'h0BEEF, 1'b0);
        lookup(32'h0BEE_F010, c, h, pa);
        check("R3 invalid slot no match", 32'(h), 0);
        check("R6 paddr kept after miss", 32'(pa), 32'h7FFE);
        check("R6 miss latency", 32'(c), FRAMES + 1);
    endtask

    task automatic t_duplicate;
        int c; logic h; logic [PA_W-1:0] pa;
        write_slot(6, 20'h55555, 1'b1);
        write_slot(2, 20'h55555, 1'b1);
        lookup(32'h5555_5777, c, h, pa);
        check("R4 lowest index wins", 32'(pa), 32'h2777);
        check("R5 latency dup", 32'(c), 4);
    endtask

    task automatic t_busy_req;
        int c = 1; int extra = 0; logic h;
        @(negedge clk);
        req = 1'b1; vaddr = 32'hFFFF_F123;
        @(negedge clk);
        vaddr = 32'h00AA_A456;
        @(negedge clk);
        req = 1'b0;
        c = 2;
        while (!done && c < 40) begin @(negedge clk); c++; end
        h = hit;
        check("R8 first request result", 32'(paddr), 32'h7123);
        check("R8 first request latency", 32'(c), FRAMES + 1);
        check("R8 hit", 32'(h), 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R8 no extra done", 32'(extra), 0);
    endtask

    task automatic t_busy_write;
        int c; logic h; logic [PA_W-1:0] pa;
        write_slot(1, 20'h0C0DE, 1'b1);
        @(negedge clk);
        req = 1'b1; vaddr = 32'h1111_1000;
        @(negedge clk);
        req = 1'b0;
        wr_en = 1'b1; wr_idx = 3'd1; wr_vpn = 20'h22222; wr_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        while (!done) @(negedge clk);
        lookup(32'h2222_2000, c, h, pa);
        check("R9 busy write discarded", 32'(h), 0);
        lookup(32'h0C0D_E042, c, h, pa);
        check("R9 old slot kept", 32'(pa), 32'h1042);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_hit();
        t_ends();
        t_invalid();
        t_duplicate();
        t_busy_req();
        t_busy_write();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule